// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that announces each bus transfer only through a three-bit status code and no strobes of its own. The generator samples that code on every rising clock edge and rebuilds the full set of bus controls from it. These controls are an address-latch pulse, a data-buffer enable, a data-direction line, and individual active-low commands for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces early variants of the two write commands for slow write targets.

The all-ones status code means the bus is idle. A transfer starts on the first clock edge at which the code moves away from idle, and it ends on the edge at which the code reads idle again. Between those two edges the generator holds the code it captured at the start. Any other code that appears during the transfer is ignored until the bus has passed through idle. The length of the transfer is set only by how long the processor keeps a non-idle code on the status lines, so wait states need no further signal.

Top module: `busctl_gen`

## Requirements
- R1: While reset is asserted, and after it is released with status at idle (111), all seven active-low commands are high, `addr_latch_en` is 0, `data_en` is 0 and `data_dir` is 1.
- R2: An edge at which status is not 111 and the previous sampled status was 111 starts a transfer. `addr_latch_en` is 1 for exactly the one clock after that edge, for every non-idle code including halt. Status held at 111 starts nothing.
- R3: The command follows the code captured at the start: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt (no command at all), 100 code fetch and 101 memory read (both drive memory read), 110 memory write.
- R4: The normal command of the captured code goes low from the second clock of the transfer (the clock after the second edge with non-idle status) and stays low until the transfer ends.
- R5: The early memory-write and early I/O-write commands go low one clock before the normal write command, in the first clock of a write transfer.
- R6: After an edge at which status is 111, every command is high and `data_en` is 0.
- R7: `data_en` is 1 exactly while a normal command (memory read, memory write, I/O read, I/O write or interrupt acknowledge) is low.
- R8: `data_dir` is 0 for the whole transfer when the captured code is 000, 001, 100 or 101, and 1 otherwise, including when the bus is idle.
- R9: A change of status from one non-idle code to another without passing through 111 starts no new transfer, causes no new address-latch pulse and does not change the active command.
- R10: At most one normal command is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; status is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat | input | 3 | Bus status code from the processor, 111 = idle |
| addr_latch_en | output | 1 | Address-latch pulse, one clock at transfer start |
| data_en | output | 1 | Data-buffer enable, active high |
| data_dir | output | 1 | Data direction: 0 = toward processor, 1 = away from processor |
| mem_rd_n | output | 1 | Memory-read command, active low |
| mem_wr_n | output | 1 | Memory-write command, active low |
| io_rd_n | output | 1 | I/O-read command, active low |
| io_wr_n | output | 1 | I/O-write command, active low |
| mem_wr_early_n | output | 1 | Early memory-write command, active low |
| io_wr_early_n | output | 1 | Early I/O-write command, active low |
| int_ack_n | output | 1 | Interrupt-acknowledge command, active low |

## Verification
The bench uses the default parameters: the command window opens in the second clock and the early writes lead it by one clock. With a three-bit status, all eight codes can be swept with transfer lengths of one to four clocks followed by idle gaps of one and two clocks. This covers the case where the transfer is so short that the normal command never appears, as well as the case where the command is held through wait states. Separate sequences switch status between two non-idle codes without passing through idle, to confirm that the captured code is kept.

// File: rtl/busctl_pkg.sv
package busctl_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_ACK   = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MEMRD = 3'b101,
        ST_MEMWR = 3'b110,
        ST_IDLE  = 3'b111
    } stat_e;

    // Command class of one status code
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic ack;
        logic rd_type;
        logic carries_data;
    } cmd_class_t;

    // Registered bus-side outputs
    typedef struct packed {
        logic ale;
        logic den;
        logic dir;
        logic mrd_n;
        logic mwr_n;
        logic iord_n;
        logic iowr_n;
        logic emwr_n;
        logic eiowr_n;
        logic ack_n;
    } bus_out_t;

    localparam bus_out_t BUS_OUT_IDLE = '{
        ale: 1'b0, den: 1'b0, dir: 1'b1,
        mrd_n: 1'b1, mwr_n: 1'b1, iord_n: 1'b1, iowr_n: 1'b1,
        emwr_n: 1'b1, eiowr_n: 1'b1, ack_n: 1'b1
    };

endpackage

// File: rtl/busctl_decode.sv
module busctl_decode
    import busctl_pkg::*;
(
    input  stat_e      code_i,
    output cmd_class_t cls_o
);

    always_comb begin
        cls_o = '0;
        unique case (code_i)
            ST_ACK: begin
                cls_o.ack          = 1'b1;
                cls_o.rd_type      = 1'b1;
                cls_o.carries_data = 1'b1;
            end
            ST_IORD: begin
                cls_o.io_rd        = 1'b1;
                cls_o.rd_type      = 1'b1;
                cls_o.carries_data = 1'b1;
            end
            ST_IOWR: begin
                cls_o.io_wr        = 1'b1;
                cls_o.carries_data = 1'b1;
            end
            ST_FETCH, ST_MEMRD: begin
                cls_o.mem_rd       = 1'b1;
                cls_o.rd_type      = 1'b1;
                cls_o.carries_data = 1'b1;
            end
            ST_MEMWR: begin
                cls_o.mem_wr       = 1'b1;
                cls_o.carries_data = 1'b1;
            end
            default: cls_o = '0; // halt and idle carry no command
        endcase
    end

endmodule

// File: rtl/busctl_seq.sv
module busctl_seq
    import busctl_pkg::*;
#(
    parameter int CMD_START = 2,
    parameter int PH_W      = $clog2(CMD_START + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  stat_e           stat_i,
    output logic [PH_W-1:0] ph_d_o,
    output stat_e           code_d_o,
    output logic            start_d_o
);

    localparam logic [PH_W-1:0] PH_IDLE = '0;
    localparam logic [PH_W-1:0] PH_MAX  = PH_W'(CMD_START);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        stat_e           code;
        stat_e           prev;
    } seq_t;

    seq_t s_d, s_q;
    logic start;

    always_comb begin
        s_d      = s_q;
        s_d.prev = stat_i;
        start    = (stat_i != ST_IDLE) && (s_q.prev == ST_IDLE);
        if (start) begin
            s_d.ph   = PH_W'(1);
            s_d.code = stat_i;
        end else if (s_q.ph != PH_IDLE) begin
            if (stat_i == ST_IDLE) begin
                s_d.ph   = PH_IDLE;
                s_d.code = ST_IDLE;
            end else if (s_q.ph != PH_MAX) begin
                s_d.ph = s_q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, code: ST_IDLE, prev: ST_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign ph_d_o    = s_d.ph;
    assign code_d_o  = s_d.code;
    assign start_d_o = start;

endmodule

// File: rtl/busctl_drive.sv
module busctl_drive
    import busctl_pkg::*;
#(
    parameter int CMD_START  = 2,
    parameter int EARLY_LEAD = 1,
    parameter int PH_W       = $clog2(CMD_START + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] ph_d_i,
    input  logic            start_d_i,
    input  cmd_class_t      cls_d_i,
    output bus_out_t        out_o
);

    localparam logic [PH_W-1:0] PH_NORM  = PH_W'(CMD_START);
    localparam logic [PH_W-1:0] PH_EARLY = PH_W'(CMD_START - EARLY_LEAD);

    bus_out_t o_d, o_q;
    logic active, norm, early;

    always_comb begin
        active = (ph_d_i != '0);
        norm   = active && (ph_d_i >= PH_NORM);
        early  = active && (ph_d_i >= PH_EARLY);

        o_d         = BUS_OUT_IDLE;
        o_d.ale     = start_d_i;
        o_d.den     = norm && cls_d_i.carries_data;
        o_d.dir     = !(active && cls_d_i.rd_type);
        o_d.mrd_n   = !(norm && cls_d_i.mem_rd);
        o_d.mwr_n   = !(norm && cls_d_i.mem_wr);
        o_d.iord_n  = !(norm && cls_d_i.io_rd);
        o_d.iowr_n  = !(norm && cls_d_i.io_wr);
        o_d.ack_n   = !(norm && cls_d_i.ack);
        o_d.emwr_n  = !(early && cls_d_i.mem_wr);
        o_d.eiowr_n = !(early && cls_d_i.io_wr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= BUS_OUT_IDLE;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_o = o_q;

endmodule

// File: rtl/busctl_gen.sv
module busctl_gen
    import busctl_pkg::*;
#(
    parameter int CMD_START  = 2,
    parameter int EARLY_LEAD = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] stat,
    output logic       addr_latch_en,
    output logic       data_en,
    output logic       data_dir,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       mem_wr_early_n,
    output logic       io_wr_early_n,
    output logic       int_ack_n
);

    localparam int PH_W = $clog2(CMD_START + 1);

    stat_e           stat_e_w;
    logic [PH_W-1:0] ph_d;
    stat_e           code_d;
    logic            start_d;
    cmd_class_t      cls_d;
    bus_out_t        bus_q;

    assign stat_e_w = stat_e'(stat);

    busctl_seq #(
        .CMD_START (CMD_START),
        .PH_W      (PH_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (stat_e_w),
        .ph_d_o    (ph_d),
        .code_d_o  (code_d),
        .start_d_o (start_d)
    );

    busctl_decode u_dec (
        .code_i (code_d),
        .cls_o  (cls_d)
    );

    busctl_drive #(
        .CMD_START  (CMD_START),
        .EARLY_LEAD (EARLY_LEAD),
        .PH_W       (PH_W)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph_d_i    (ph_d),
        .start_d_i (start_d),
        .cls_d_i   (cls_d),
        .out_o     (bus_q)
    );

    assign addr_latch_en  = bus_q.ale;
    assign data_en        = bus_q.den;
    assign data_dir       = bus_q.dir;
    assign mem_rd_n       = bus_q.mrd_n;
    assign mem_wr_n       = bus_q.mwr_n;
    assign io_rd_n        = bus_q.iord_n;
    assign io_wr_n        = bus_q.iowr_n;
    assign mem_wr_early_n = bus_q.emwr_n;
    assign io_wr_early_n  = bus_q.eiowr_n;
    assign int_ack_n      = bus_q.ack_n;

endmodule

// File: rtl/busctl_gen_chk.sv
module busctl_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] stat,
    input logic       addr_latch_en,
    input logic       data_en,
    input logic       data_dir,
    input logic       mem_rd_n,
    input logic       mem_wr_n,
    input logic       io_rd_n,
    input logic       io_wr_n,
    input logic       mem_wr_early_n,
    input logic       io_wr_early_n,
    input logic       int_ack_n
);

    logic [4:0] norm_act;
    assign norm_act = {~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n, ~int_ack_n};

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch_en |=> !addr_latch_en);

    assert_ale_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_latch_en) |-> $past(stat) != 3'b111);

    assert_mem_early_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $past(!mem_wr_early_n));

    assert_io_early_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_wr_n) |-> $past(!io_wr_early_n));

    assert_idle_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat == 3'b111 |=> (norm_act == 5'b0) && !data_en
                           && mem_wr_early_n && io_wr_early_n);

    assert_den_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_en == (norm_act != 5'b0));

    assert_dir_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_dir) |-> $past(stat) != 3'b111);

    assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(norm_act));

endmodule

bind busctl_gen busctl_gen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stat           (stat),
    .addr_latch_en  (addr_latch_en),
    .data_en        (data_en),
    .data_dir       (data_dir),
    .mem_rd_n       (mem_rd_n),
    .mem_wr_n       (mem_wr_n),
    .io_rd_n        (io_rd_n),
    .io_wr_n        (io_wr_n),
    .mem_wr_early_n (mem_wr_early_n),
    .io_wr_early_n  (io_wr_early_n),
    .int_ack_n      (int_ack_n)
);

// File: tb/busctl_gen_bench.sv
module busctl_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] stat = 3'b111;
    logic addr_latch_en, data_en, data_dir;
    logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic mem_wr_early_n, io_wr_early_n, int_ack_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    busctl_gen u_busctl_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .stat           (stat),
        .addr_latch_en  (addr_latch_en),
        .data_en        (data_en),
        .data_dir       (data_dir),
        .mem_rd_n       (mem_rd_n),
        .mem_wr_n       (mem_wr_n),
        .io_rd_n        (io_rd_n),
        .io_wr_n        (io_wr_n),
        .mem_wr_early_n (mem_wr_early_n),
        .io_wr_early_n  (io_wr_early_n),
        .int_ack_n      (int_ack_n)
    );

    // {ale, den, dir, mrd_n, mwr_n, iord_n, iowr_n, emwr_n, eiowr_n, ack_n}
    function automatic logic [9:0] observed();
        return {addr_latch_en, data_en, data_dir, mem_rd_n, mem_wr_n,
                io_rd_n, io_wr_n, mem_wr_early_n, io_wr_early_n, int_ack_n};
    endfunction

    // Expected outputs for captured code c in transfer clock ph (0 = idle)
    function automatic logic [9:0] model(input logic [2:0] c, input int ph, input bit ale);
        bit act  = (ph != 0);
        bit norm = (ph >= 2);           // R4: second clock onward
        bit mrd  = (c == 3'b100) || (c == 3'b101);  // R3
        bit mwr  = (c == 3'b110);
        bit iord = (c == 3'b001);
        bit iowr = (c == 3'b010);
        bit ack  = (c == 3'b000);
        bit rd   = mrd || iord || ack;  // R8
        bit dat  = mrd || mwr || iord || iowr || ack; // R7
        return {ale, norm && dat, !(act && rd),
                !(norm && mrd), !(norm && mwr), !(norm && iord), !(norm && iowr),
                !(act && mwr), !(act && iowr), !(norm && ack)}; // R5 early = clock 1
    endfunction

    task automatic check(input string tag, input logic [9:0] exp);
        logic [9:0] got = observed();
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // At a negedge: hold code for len edges, then idle for gap edges
    task automatic transfer(input logic [2:0] code, input int len, input int gap);
        for (int j = 1; j <= len + gap; j++) begin
            int  ph;
            bit  ale;
            stat = (j <= len) ? code : 3'b111;
            @(posedge clk);
            @(negedge clk);
            if (code == 3'b111 || j > len) ph = 0;
            else ph = (j >= 2) ? 2 : 1;
            ale = (code != 3'b111) && (j == 1);
            if (code == 3'b111)
                check("R2 idle starts nothing", model(3'b111, 0, 1'b0));
            else if (ph == 0)
                check("R6 end on idle", model(code, 0, 1'b0));
            else if (ph == 1)
                check("R2 R5 R8 first clock", model(code, ph, ale));
            else
                check("R3 R4 R7 R8 command window", model(code, ph, ale));
        end
    endtask

    // R9: switch a to b without passing through idle
    task automatic switch_codes(input logic [2:0] a, input logic [2:0] b);
        for (int j = 1; j <= 6; j++) begin
            int ph;
            stat = (j <= 2) ? a : (j <= 4) ? b : 3'b111;
            @(posedge clk);
            @(negedge clk);
            ph = (j > 4) ? 0 : (j >= 2) ? 2 : 1;
            check("R9 code change ignored", model(a, ph, j == 1));
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 during reset", model(3'b111, 0, 1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", model(3'b111, 0, 1'b0));

        for (int c = 0; c < 8; c++)
            for (int len = 1; len <= 4; len++)
                for (int gap = 1; gap <= 2; gap++)
                    transfer(3'(c), len, gap);

        switch_codes(3'b110, 3'b101);
        switch_codes(3'b001, 3'b010);
        switch_codes(3'b011, 3'b000);
        switch_codes(3'b100, 3'b110);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule